// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in-first-out buffer for 9-bit words. Its writer and its reader run on clocks that are fully unrelated, and both sides may work in the same cycle. The words sit in an inferred dual-port memory whose depth is a parameter. The write and read pointers cross between the clock domains as Gray code through two-flop synchronizers. One spare pointer bit tells a full buffer from an empty one.

Each side reports its own state. The write side drives a full or room-available flag, a half-full flag and an almost-full flag. The read side drives an empty or word-ready flag and an almost-empty flag. The two almost thresholds live in one offset vector. A master reset loads that vector with one of two preset values. After reset it can be rewritten one bit per write clock or one data word per write.

A read-timing mode is latched at the end of master reset:
- Standard mode: a read request presents the next word.
- Fall-through mode: the oldest word shows on the output with no request.

A partial reset empties the buffer but keeps the offsets and the mode. A retransmit request rewinds the reader to location 0 so the stream can be replayed. An output-enable input releases the data bus.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words come out in the order they were written, all 9 bits intact. In standard mode, a read request seen at a read-clock edge with `rd_stat` low puts the next word on `dout` at that edge.
- R2: After DEPTH writes with no reads, `wr_stat` is 1 in standard mode. Further writes are dropped, so the reader then gets exactly the first DEPTH words.
- R3: In standard mode `rd_stat` is 1 while no word is stored. A read request while empty leaves `dout` and the read position unchanged.
- R4: `half_full` is 1 exactly when the write side counts more than DEPTH/2 stored words.
- R5: `almost_empty` is 1 when the stored count is at most the almost-empty offset. `almost_full` is 1 when the count is at least DEPTH minus the almost-full offset.
- R6: Master reset sets both offsets to DEF_LO when `dflt_sel` is 0, or to DEF_HI when it is 1.
- R7: The offsets form one vector of 2*OW bits, OW = log2(DEPTH). The almost-empty offset is in bits [OW-1:0] and the almost-full offset is in bits [2*OW-1:OW].
  - A write with `ld_par` high goes into this vector, not into the buffer.
  - The k-th such write fills bits [9k+8:9k] from `din`, starting at k = 0 and wrapping after the last chunk.
- R8: Each write-clock edge with `ser_en` high (and no parallel load) stores `cfg_si` into the next bit of the same vector. Filling starts at bit 0 and wraps after bit 2*OW-1.
- R9: Master reset empties the buffer and restores the default offsets. The value of `cfg_si` when reset ends selects the mode: 0 for standard, 1 for fall-through.
- R10: Partial reset empties the buffer but keeps the programmed offsets and the selected mode.
- R11: In fall-through mode, `rd_stat` = 1 means a valid word is on `dout`, shown with no read request. A read request then moves to the next word. `wr_stat` = 1 means there is room.
- R12: A one-cycle `rtx` pulse on the read clock rewinds the read position to location 0. The next standard read returns the first word written since reset.
- R13: With `oe` low the `dout` pins are undriven. With `oe` high they carry the held output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, sampled by both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled by both clocks |
| wr_en | input | 1 | Write request |
| din | input | DW (9) | Write data, or offset chunk during a parallel load |
| ld_par | input | 1 | Routes writes into the offset vector |
| ser_en | input | 1 | Enables serial offset loading |
| cfg_si | input | 1 | Mode select at end of master reset, serial offset bit afterwards |
| dflt_sel | input | 1 | Picks the preset offset applied by master reset |
| rd_en | input | 1 | Read request |
| rtx | input | 1 | Retransmit request, read clock domain |
| oe | input | 1 | Output enable for `dout` |
| dout | output | DW (9) | Read data, high impedance when `oe` is low |
| rd_stat | output | 1 | Standard: empty; fall-through: word ready |
| wr_stat | output | 1 | Standard: full; fall-through: room available |
| half_full | output | 1 | More than half of the storage in use |
| almost_empty | output | 1 | Count at or below the almost-empty offset |
| almost_full | output | 1 | Count at or above DEPTH minus the almost-full offset |

## Verification
Results that depend only on the write side follow the write-clock edge that took the write: `wr_stat`, `half_full` and `almost_full`. A standard read or a retransmit changes `dout` and the read position at the read-clock edge that samples the request.

Anything that crosses domains needs two synchronizer stages plus the pointer register. This covers the reader seeing a new word, `almost_empty`, and the writer seeing freed room. Such results are due within three edges of the far clock.

Every task drives its inputs on falling edges and samples on falling edges. Before reading a flag that depends on the other domain, a task waits eight falling edges of each clock. Each cross-domain flag is therefore read only once it is due.

// File: rtl/dcf_pkg.sv
// Package: shared types and pointer-code helpers for the dual-clock FIFO.
// Assumes pointers are at most 32 bits wide; callers cast to their width.
package dcf_pkg;

    // Read-timing mode latched at the end of master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    // Binary to reflected Gray code.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Reflected Gray code back to binary.
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
// Module: two-flop synchronizer for a Gray-coded pointer.
// Assumes the input changes by at most one bit between samples,
// so the captured value is always an old or a new pointer.
module dcf_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Two-stage capture into the destination clock, cleared by sync reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_mem.sv
// Module: simple dual-port storage, written on the write clock and read
// through a registered port on the read clock.
// Assumes the controllers never read a location being written in the
// same interval (pointer synchronization guarantees this).
module dcf_mem #(
    parameter int DW = 9,
    parameter int AW = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rrst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write port: store one word per accepted write.
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    // Read port: output register holds the last word fetched.
    always_ff @(posedge rclk) begin
        if (!rrst_n)  rdata <= '0;
        else if (re)  rdata <= store[raddr];
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
// Module: write-side control. Owns the write pointer, the full, half-full
// and almost-full flags, the offset vector with its serial and parallel
// load paths, and a write-domain copy of the read-timing mode.
// Assumes the offsets are only changed while the read side is idle; the
// read side uses them without synchronization.
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int DW     = 9,
    parameter int AW     = 10,
    parameter int OW     = 10,
    parameter int DEF_LO = 7,
    parameter int DEF_HI = 63
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          wr_en,
    input  logic          ld_par,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic          dflt_sel,
    input  logic [DW-1:0] din,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic [OW-1:0] ae_off,
    output logic [OW-1:0] af_off,
    output logic          wr_stat,
    output logic          half_full,
    output logic          almost_full
);
    localparam int PW  = AW + 1;
    localparam int VW  = 2 * OW;
    localparam int NCH = (VW + DW - 1) / DW;
    localparam int CIW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int SIW = $clog2(VW);

    logic           rst_n;
    logic [PW-1:0]  wbin;
    logic [PW-1:0]  rbin_s;
    logic [PW-1:0]  wcount;
    logic [PW-1:0]  af_level;
    logic           full;
    logic           push;
    rd_mode_e       mode;
    logic [VW-1:0]  offs;
    logic [CIW-1:0] chunk;
    logic [SIW-1:0] sbit;
    logic [OW-1:0]  dflt_v;

    assign rst_n    = mrst_n & prst_n;
    assign rbin_s   = PW'(gray2bin(32'(rgray_s)));
    assign wcount   = wbin - rbin_s;
    assign full     = (wcount == PW'(DEPTH));
    assign push     = wr_en && !ld_par && !full;
    assign we       = push;
    assign waddr    = wbin[AW-1:0];
    assign af_level = PW'(DEPTH) - PW'(af_off);
    assign dflt_v   = dflt_sel ? OW'(DEF_HI) : OW'(DEF_LO);
    assign ae_off   = offs[OW-1:0];
    assign af_off   = offs[VW-1:OW];

    // Write pointer in binary and Gray form; both resets clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (push) begin
            wbin  <= wbin + PW'(1);
            wgray <= PW'(bin2gray(32'(wbin + PW'(1))));
        end
    end

    // Mode copy: follows the mode pin only while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) mode <= rd_mode_e'(ser_in);
    end

    // Offset vector: defaults on master reset, parallel chunk or serial bit loads.
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            offs  <= {dflt_v, dflt_v};
            chunk <= '0;
            sbit  <= '0;
        end else if (!prst_n) begin
            chunk <= '0;
            sbit  <= '0;
        end else if (wr_en && ld_par) begin
            for (int b = 0; b < VW; b++) begin
                if (CIW'(b / DW) == chunk) offs[b] <= din[b % DW];
            end
            chunk <= (chunk == CIW'(NCH - 1)) ? '0 : chunk + CIW'(1);
        end else if (ser_en) begin
            offs[sbit] <= ser_in;
            sbit <= (sbit == SIW'(VW - 1)) ? '0 : sbit + SIW'(1);
        end
    end

    // Status outputs; polarity of the full flag follows the mode.
    always_comb begin
        wr_stat     = (mode == MODE_FWFT) ? !full : full;
        half_full   = (wcount > PW'(DEPTH / 2));
        almost_full = (wcount >= af_level);
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !ld_par) |=> $stable(wbin));

    // R7
    par_load_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ld_par) |=> $stable(wbin));
endmodule

// File: rtl/dcf_rd_ctl.sv
// Module: read-side control. Owns the read pointer, the empty or
// word-ready flag, almost-empty, retransmit and the fall-through prefetch.
// Assumes retransmit is used only when no more than DEPTH words were
// written since reset and while the write side is idle.
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10,
    parameter int OW    = 10
) (
    input  logic          clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          mode_pin,
    input  logic          rd_en,
    input  logic          rtx,
    input  logic [AW:0]   wgray_s,
    input  logic [OW-1:0] ae_off,
    output logic          re,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic          rd_stat,
    output logic          almost_empty
);
    localparam int PW = AW + 1;

    logic          rst_n;
    logic [PW-1:0] rbin;
    logic [PW-1:0] wbin_s;
    logic [PW-1:0] rcount;
    logic          mem_empty;
    logic          ov;
    logic          pop;
    rd_mode_e      mode;

    assign rst_n     = mrst_n & prst_n;
    assign wbin_s    = PW'(gray2bin(32'(wgray_s)));
    assign rcount    = wbin_s - rbin;
    assign mem_empty = (rcount == '0);
    assign re        = pop;
    assign raddr     = rbin[AW-1:0];

    // Fetch decision: on request in standard mode, on free output slot in fall-through.
    always_comb begin
        if (rtx)                     pop = 1'b0;
        else if (mode == MODE_FWFT)  pop = !mem_empty && (!ov || rd_en);
        else                         pop = !mem_empty && rd_en;
    end

    // Mode copy: follows the mode pin only while master reset is held.
    always_ff @(posedge clk) begin
        if (!mrst_n) mode <= rd_mode_e'(mode_pin);
    end

    // Read pointer, rewind on retransmit, and output-valid tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            ov    <= 1'b0;
        end else if (rtx) begin
            rbin  <= '0;
            rgray <= '0;
            ov    <= 1'b0;
        end else begin
            if (pop) begin
                rbin  <= rbin + PW'(1);
                rgray <= PW'(bin2gray(32'(rbin + PW'(1))));
            end
            if (mode == MODE_FWFT) begin
                if (pop)        ov <= 1'b1;
                else if (rd_en) ov <= 1'b0;
            end
        end
    end

    // Status outputs; the empty flag becomes word-ready in fall-through.
    always_comb begin
        rd_stat      = (mode == MODE_FWFT) ? ov : mem_empty;
        almost_empty = (rcount <= PW'(ae_off));
    end

    // R3
    rd_empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_STD) && mem_empty && rd_en && !rtx) |=> $stable(rbin));

    // R11
    fwft_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MODE_FWFT) && ov && !rd_en && !rtx) |=> ov);

    // R12
    rtx_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtx |=> (rbin == '0));
endmodule

// File: rtl/dcfifo_pflag.sv
// Module: top of the dual-clock FIFO with programmable level flags.
// Ties the write control, read control, storage and the two pointer
// synchronizers together and drives the tri-state data output.
// Assumes both reset inputs are held low for several cycles of each clock.
module dcfifo_pflag #(
    parameter int DEPTH  = 1024,
    parameter int DW     = 9,
    parameter int DEF_LO = 7,
    parameter int DEF_HI = 63
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    input  logic          ld_par,
    input  logic          ser_en,
    input  logic          cfg_si,
    input  logic          dflt_sel,
    input  logic          rd_en,
    input  logic          rtx,
    input  logic          oe,
    output wire  [DW-1:0] dout,
    output logic          rd_stat,
    output logic          wr_stat,
    output logic          half_full,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam int AW = $clog2(DEPTH);
    localparam int OW = AW;
    localparam int PW = AW + 1;

    logic          ptr_rst_n;
    logic          we, re;
    logic [AW-1:0] waddr, raddr;
    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [OW-1:0] ae_off, af_off;
    logic [DW-1:0] rdata;

    assign ptr_rst_n = mrst_n & prst_n;

    dcf_wr_ctl #(
        .DEPTH(DEPTH), .DW(DW), .AW(AW), .OW(OW),
        .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)
    ) u_wr (
        .clk(wr_clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .wr_en(wr_en), .ld_par(ld_par), .ser_en(ser_en), .ser_in(cfg_si),
        .dflt_sel(dflt_sel), .din(din), .rgray_s(rgray_s),
        .we(we), .waddr(waddr), .wgray(wgray),
        .ae_off(ae_off), .af_off(af_off),
        .wr_stat(wr_stat), .half_full(half_full), .almost_full(almost_full)
    );

    dcf_rd_ctl #(
        .DEPTH(DEPTH), .AW(AW), .OW(OW)
    ) u_rd (
        .clk(rd_clk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_pin(cfg_si),
        .rd_en(rd_en), .rtx(rtx), .wgray_s(wgray_s), .ae_off(ae_off),
        .re(re), .raddr(raddr), .rgray(rgray),
        .rd_stat(rd_stat), .almost_empty(almost_empty)
    );

    dcf_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(din),
        .rclk(rd_clk), .rrst_n(ptr_rst_n), .re(re), .raddr(raddr),
        .rdata(rdata)
    );

    dcf_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(ptr_rst_n), .d(wgray), .q(wgray_s)
    );

    dcf_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(ptr_rst_n), .d(rgray), .q(rgray_s)
    );

    assign dout = oe ? rdata : {DW{1'bz}};
endmodule

// File: tb/tb_dcfifo_pflag.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dcfifo_pflag;
    localparam int DEPTH = 32;
    localparam int DW    = 9;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic          wr_en = 1'b0, ld_par = 1'b0, ser_en = 1'b0;
    logic          cfg_si = 1'b0, dflt_sel = 1'b0;
    logic          rd_en = 1'b0, rtx = 1'b0, oe = 1'b1;
    logic [DW-1:0] din = '0;
    wire  [DW-1:0] dbus;
    logic          rd_stat, wr_stat, half_full, almost_empty, almost_full;

    int checks = 0;
    int errors = 0;
    int wseq   = 0;

    assign (weak0, weak1) dbus = 9'h155;

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcfifo_pflag #(.DEPTH(DEPTH), .DW(DW), .DEF_LO(3), .DEF_HI(9)) dut (
        .wr_clk(wclk), .rd_clk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .wr_en(wr_en), .din(din), .ld_par(ld_par), .ser_en(ser_en),
        .cfg_si(cfg_si), .dflt_sel(dflt_sel), .rd_en(rd_en), .rtx(rtx),
        .oe(oe), .dout(dbus), .rd_stat(rd_stat), .wr_stat(wr_stat),
        .half_full(half_full), .almost_empty(almost_empty),
        .almost_full(almost_full)
    );

    function automatic logic [DW-1:0] dv(input int i);
        return DW'((i * 37 + 11) % 512);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
    endtask

    task automatic do_mrst(input logic mode, input logic dsel);
        cfg_si = mode; dflt_sel = dsel; mrst_n = 1'b0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        mrst_n = 1'b1; cfg_si = 1'b0;
        wseq = 0;
        settle();
    endtask

    task automatic do_prst();
        prst_n = 1'b0;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        prst_n = 1'b1;
        wseq = 0;
        settle();
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk); wr_en = 1'b1; din = dv(wseq); wseq++;
        end
        @(negedge wclk); wr_en = 1'b0;
    endtask

    task automatic pull(output logic [DW-1:0] q);
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        q = dbus;
    endtask

    task automatic t_reset();
        do_mrst(1'b0, 1'b0);
        chk("R9 empty after master reset", rd_stat, 1);
        chk("R9 not full after master reset", wr_stat, 0);
        chk("R5 almost_empty at reset", almost_empty, 1);
        chk("R4 half_full at reset", half_full, 0);
        chk("R5 almost_full at reset", almost_full, 0);
    endtask

    task automatic t_fill_drain();
        logic [DW-1:0] q;
        push(3);  settle(); chk("R6 R5 ae at 3 with default 3", almost_empty, 1);
        push(1);  settle(); chk("R5 ae at 4", almost_empty, 0);
        chk("R3 not empty with data", rd_stat, 0);
        push(12); settle(); chk("R4 half at 16", half_full, 0);
        push(1);  settle(); chk("R4 half at 17", half_full, 1);
        push(11); settle(); chk("R5 af at 28", almost_full, 0);
        push(1);  settle(); chk("R5 af at 29", almost_full, 1);
        push(3);  settle(); chk("R2 full at DEPTH", wr_stat, 1);
        push(2);  settle(); chk("R2 still full", wr_stat, 1);
        for (int k = 0; k < DEPTH; k++) begin
            pull(q);
            chk("R1 R2 readback order", q, dv(k));
        end
        settle();
        chk("R3 empty after drain", rd_stat, 1);
        pull(q);
        chk("R3 read while empty holds dout", q, dv(DEPTH - 1));
        push(1); settle();
        pull(q);
        chk("R3 no pointer slip on empty read", q, dv(DEPTH + 2));
    endtask

    task automatic t_parallel();
        do_mrst(1'b0, 1'b0);
        @(negedge wclk); ld_par = 1'b1; wr_en = 1'b1; din = 9'h0C5;
        @(negedge wclk); din = 9'h000;
        @(negedge wclk); ld_par = 1'b0; wr_en = 1'b0;
        settle();
        chk("R7 parallel load writes no data", rd_stat, 1);
        push(5);  settle(); chk("R7 ae offset 5 at 5", almost_empty, 1);
        push(1);  settle(); chk("R7 ae offset 5 at 6", almost_empty, 0);
        push(19); settle(); chk("R7 af offset 6 at 25", almost_full, 0);
        push(1);  settle(); chk("R7 af offset 6 at 26", almost_full, 1);
        do_prst();
        chk("R10 empty after partial reset", rd_stat, 1);
        push(5);  settle(); chk("R10 offset kept at 5", almost_empty, 1);
        push(1);  settle(); chk("R10 offset kept at 6", almost_empty, 0);
    endtask

    task automatic t_serial();
        logic [9:0] vec;
        vec = 10'h041;
        do_mrst(1'b0, 1'b0);
        for (int i = 0; i < 10; i++) begin
            @(negedge wclk); ser_en = 1'b1; cfg_si = vec[i];
        end
        @(negedge wclk); ser_en = 1'b0; cfg_si = 1'b0;
        push(1);  settle(); chk("R8 serial ae 1 at 1", almost_empty, 1);
        push(1);  settle(); chk("R8 serial ae 1 at 2", almost_empty, 0);
        push(27); settle(); chk("R8 serial af 2 at 29", almost_full, 0);
        push(1);  settle(); chk("R8 serial af 2 at 30", almost_full, 1);
        do_mrst(1'b0, 1'b1);
        chk("R9 master reset empties", rd_stat, 1);
        push(9);  settle(); chk("R6 ae DEF_HI at 9", almost_empty, 1);
        push(1);  settle(); chk("R6 ae DEF_HI at 10", almost_empty, 0);
        push(12); settle(); chk("R6 af DEF_HI at 22", almost_full, 0);
        push(1);  settle(); chk("R6 af DEF_HI at 23", almost_full, 1);
    endtask

    task automatic t_retransmit();
        logic [DW-1:0] q;
        do_mrst(1'b0, 1'b0);
        push(4); settle();
        pull(q); chk("R1 first word", q, dv(0));
        pull(q); chk("R1 second word", q, dv(1));
        @(negedge rclk); rtx = 1'b1;
        @(negedge rclk); rtx = 1'b0;
        settle();
        pull(q); chk("R12 replay starts at first word", q, dv(0));
        pull(q); chk("R12 replay continues", q, dv(1));
        oe = 1'b0; #1;
        chk("R13 bus released with oe low", dbus, 9'h155);
        oe = 1'b1; #1;
        chk("R13 bus driven with oe high", dbus, dv(1));
    endtask

    task automatic t_fwft();
        do_mrst(1'b1, 1'b0);
        chk("R9 R11 no word ready after reset", rd_stat, 0);
        chk("R11 room flag after reset", wr_stat, 1);
        push(2); settle();
        chk("R11 word ready without read", rd_stat, 1);
        chk("R11 first word falls through", dbus, dv(0));
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        chk("R11 read moves to next word", dbus, dv(1));
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        settle();
        chk("R11 not ready after last word", rd_stat, 0);
        do_prst();
        chk("R10 mode kept, room flag", wr_stat, 1);
        chk("R10 mode kept, ready flag low", rd_stat, 0);
        push(1); settle();
        chk("R10 fall-through kept after partial reset", rd_stat, 1);
        chk("R10 word shown without read", dbus, dv(0));
    endtask

    initial begin
        t_reset();
        t_fill_drain();
        t_parallel();
        t_serial();
        t_retransmit();
        t_fwft();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule